// File: doc/BRIEF.md
# Hierarchical Tile Triangle Traversal

This block receives one triangle that is already known to touch a 16×16 pixel tile and walks that tile as a tree of square regions, so that it finds the covered pixels without testing every one of them. The triangle arrives as three edge planes. The block also takes one depth plane, one attribute plane, the tile origin and an optional table with four maximum-depth entries. The block first tests the four 8×8 quarters of the tile. It then descends into the 4×4 and 2×2 regions of any region that survives. A region that fails a test is dropped together with all of its children. Each surviving 2×2 region comes out as a quad: a position, a 4-bit coverage mask, the attribute value at the quad's top-left pixel, and the horizontal and vertical differences of that attribute.

A controller holds the triangle in registers and starts a walk with a one-cycle `start` pulse. It then collects quads from `quad_valid` until the `done` pulse arrives. The walk performs one region test per clock. Its length therefore shrinks with the area that the triangle leaves empty or that the depth table rejects.

The controller is a four-state machine. IDLE waits for `start`, latches all triangle inputs and moves to L8. L8 tests an 8×8 region: on a pass it goes to L4, and on a fail it steps to the next 8×8 region. L4 tests a 4×4 region: on a pass it goes to L2, and on a fail it steps to the next sibling, or climbs back to L8 when the siblings are used up. L2 evaluates one quad, emits it if any pixel is covered, and steps to the next quad. It climbs to L4 or L8 when a group of four is complete. Stepping past the last region of the tile returns the machine to IDLE and raises `done`.

Top module: `tile_traverse`

## Requirements
- R1: After reset `quad_valid` and `done` are low, and they stay low until a walk is started.
- R2: The value of an edge plane at tile pixel (px,py), where 0..15 counts from the tile origin, is A*(2px+1)+B*(2py+1)+C. This is the plane at the pixel centre, with the coefficients given as signed CW-bit numbers in half-pixel units. Edge e takes its coefficients from bits [e*CW +: CW] of `edge_a`, `edge_b` and `edge_c`. A pixel is covered when all three edge values are ≥ 0. Bit k of `quad_mask` belongs to the pixel at offset (k mod 2, k div 2) inside the quad, so bit 0 is the top-left pixel, bit 1 the top-right, bit 2 the bottom-left and bit 3 the bottom-right.
- R3: The four 8×8 regions are always tested. The 4×4 children of a passing 8×8 region are tested, and then the 2×2 children of a passing 4×4 region. A region fails when, for any one edge, the largest edge value over its pixel centres is negative. A failing region produces no quads, and none of its children are visited.
- R4: Each region test takes exactly one clock. `done` is seen N cycles after the clock edge that captures `start`, where N is the number of regions tested.
- R5: Children are visited in Z order (top-left, top-right, bottom-left, bottom-right) at every level. Quads of one walk therefore leave in strictly increasing Z index.
- R6: A 2×2 region produces a quad only if its coverage mask is non-zero.
- R7: When `zcull_en` is high, an 8×8 region with Z index i fails if the smallest depth-plane value over its pixel centres is greater than the signed entry at bits [i*(CW+8) +: CW+8] of `zmax_tbl`. The depth plane uses the same encoding as the edges in R2. An equal value does not cull the region. When `zcull_en` is low the table has no effect.
- R8: `quad_attr` is the attribute plane (encoded as in R2) at the quad's top-left pixel. `quad_dx` is the value at the top-right pixel minus that value, and `quad_dy` is the value at the bottom-left pixel minus that value.
- R9: `quad_x` and `quad_y` are the tile origin plus the pixel offset of the quad's top-left pixel within the tile.
- R10: `done` is high for a single cycle. `start` is taken only in IDLE. A `start` pulse, or a change of any triangle input, during a walk has no effect on that walk's output.
- R11: When the last region tested is a quad with coverage, that quad and `done` appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk with the present inputs (taken in IDLE only) |
| edge_a | input | 3*CW | x coefficients of the three edges |
| edge_b | input | 3*CW | y coefficients of the three edges |
| edge_c | input | 3*CW | Constant terms of the three edges |
| tile_x | input | XW | Tile origin, x |
| tile_y | input | XW | Tile origin, y |
| attr_a | input | CW | Attribute plane x coefficient |
| attr_b | input | CW | Attribute plane y coefficient |
| attr_c | input | CW | Attribute plane constant |
| depth_a | input | CW | Depth plane x coefficient |
| depth_b | input | CW | Depth plane y coefficient |
| depth_c | input | CW | Depth plane constant |
| zcull_en | input | 1 | Enable depth rejection of 8×8 regions |
| zmax_tbl | input | 4*(CW+8) | Per-8×8-region maximum depth, Z order |
| quad_valid | output | 1 | A quad is presented this cycle |
| quad_x | output | XW | Quad top-left pixel, x |
| quad_y | output | XW | Quad top-left pixel, y |
| quad_mask | output | 4 | Pixel coverage of the quad |
| quad_attr | output | CW+8 | Attribute at the top-left pixel |
| quad_dx | output | CW+8 | Attribute difference along x |
| quad_dy | output | CW+8 | Attribute difference along y |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
Two things can fall in the same cycle: the emission of the final quad and the end-of-walk pulse. This happens whenever the bottom-right quad of the tile is covered, for example with full coverage or with random triangles that reach that corner. For such cases the bench model records whether the last region it tested emitted a quad. When `done` arrives, the bench judges the quad seen in that cycle against the quad list and checks that `quad_valid` agrees with the recorded flag. Separately, a `start` pulse and changed inputs are injected in the middle of some walks; the quad stream and the cycle count must still match the triangle that was latched.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L8   = 2'd1,
        ST_L4   = 2'd2,
        ST_L2   = 2'd3
    } walk_state_e;
endpackage

// File: rtl/tt_plane_range.sv
// Extreme (max or min) of a half-pixel-encoded plane over the pixel centres
// of a square region whose corner is org and whose side is span+1 pixels.
module tt_plane_range #(
    parameter int CW       = 16,
    parameter int VW       = CW + 8,
    parameter bit PICK_MAX = 1'b1
)(
    input  logic signed [CW-1:0] a,
    input  logic signed [CW-1:0] b,
    input  logic signed [CW-1:0] c,
    input  logic        [3:0]    org_x,
    input  logic        [3:0]    org_y,
    input  logic        [3:0]    span,
    output logic signed [VW-1:0] ext
);
    localparam int PW = 6;

    logic [PW-1:0] cx_lo, cx_hi, cy_lo, cy_hi, cx_sel, cy_sel;
    logic signed [VW-1:0] a_w, b_w, c_w;

    assign a_w   = {{(VW-CW){a[CW-1]}}, a};
    assign b_w   = {{(VW-CW){b[CW-1]}}, b};
    assign c_w   = {{(VW-CW){c[CW-1]}}, c};
    assign cx_lo = {1'b0, org_x, 1'b1};
    assign cy_lo = {1'b0, org_y, 1'b1};
    assign cx_hi = cx_lo + {1'b0, span, 1'b0};
    assign cy_hi = cy_lo + {1'b0, span, 1'b0};

    generate
        if (PICK_MAX) begin : g_max
            assign cx_sel = a[CW-1] ? cx_lo : cx_hi;
            assign cy_sel = b[CW-1] ? cy_lo : cy_hi;
        end else begin : g_min
            assign cx_sel = a[CW-1] ? cx_hi : cx_lo;
            assign cy_sel = b[CW-1] ? cy_hi : cy_lo;
        end
    endgenerate

    assign ext = a_w * $signed({{(VW-PW){1'b0}}, cx_sel})
               + b_w * $signed({{(VW-PW){1'b0}}, cy_sel})
               + c_w;
endmodule

// File: rtl/tt_quad_plane.sv
// Plane values at the four pixel centres of a 2x2 quad; element k is the
// pixel at offset (k mod 2, k div 2).
module tt_quad_plane #(
    parameter int CW = 16,
    parameter int VW = CW + 8
)(
    input  logic signed [CW-1:0]   a,
    input  logic signed [CW-1:0]   b,
    input  logic signed [CW-1:0]   c,
    input  logic        [2:0]      qx,
    input  logic        [2:0]      qy,
    output logic [3:0][VW-1:0]     val
);
    logic signed [VW-1:0] a_w, b_w, c_w;

    assign a_w = {{(VW-CW){a[CW-1]}}, a};
    assign b_w = {{(VW-CW){b[CW-1]}}, b};
    assign c_w = {{(VW-CW){c[CW-1]}}, c};

    generate
        for (genvar k = 0; k < 4; k++) begin : g_pix
            localparam logic KX = 1'(k % 2);
            localparam logic KY = 1'(k / 2);
            assign val[k] = a_w * $signed({{(VW-5){1'b0}}, qx, KX, 1'b1})
                          + b_w * $signed({{(VW-5){1'b0}}, qy, KY, 1'b1})
                          + c_w;
        end
    endgenerate
endmodule

// File: rtl/tile_traverse.sv
module tile_traverse
    import tt_pkg::*;
#(
    parameter  int CW = 16,
    parameter  int XW = 12,
    localparam int VW = CW + 8,
    localparam int NE = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NE*CW-1:0]  edge_a,
    input  logic [NE*CW-1:0]  edge_b,
    input  logic [NE*CW-1:0]  edge_c,
    input  logic [XW-1:0]     tile_x,
    input  logic [XW-1:0]     tile_y,
    input  logic [CW-1:0]     attr_a,
    input  logic [CW-1:0]     attr_b,
    input  logic [CW-1:0]     attr_c,
    input  logic [CW-1:0]     depth_a,
    input  logic [CW-1:0]     depth_b,
    input  logic [CW-1:0]     depth_c,
    input  logic              zcull_en,
    input  logic [4*VW-1:0]   zmax_tbl,
    output logic              quad_valid,
    output logic [XW-1:0]     quad_x,
    output logic [XW-1:0]     quad_y,
    output logic [3:0]        quad_mask,
    output logic [VW-1:0]     quad_attr,
    output logic [VW-1:0]     quad_dx,
    output logic [VW-1:0]     quad_dy,
    output logic              done
);
    walk_state_e st, st_nx;
    logic [5:0]  q, q_nx;           // Z-order quad index: {y8,x8,y4,x4,y2,x2}
    logic        load, finish, advance;
    logic [6:0]  adv;

    // triangle held for the whole walk
    logic [NE*CW-1:0] ea_q, eb_q, ec_q;
    logic [CW-1:0]    ua_q, ub_q, uc_q, za_q, zb_q, zc_q;
    logic [XW-1:0]    tx_q, ty_q;
    logic             zen_q;
    logic [4*VW-1:0]  zmax_q;

    logic [3:0] org_x, org_y, span;
    logic signed [VW-1:0] e_hi [NE];
    logic [3:0][VW-1:0]   e_px [NE];
    logic [3:0][VW-1:0]   u_px;
    logic signed [VW-1:0] z_lo, zmax_sel;
    logic                 node_pass;
    logic [3:0]           cov;

    assign org_x    = {q[4], q[2], q[0], 1'b0};
    assign org_y    = {q[5], q[3], q[1], 1'b0};
    assign zmax_sel = $signed(zmax_q[q[5:4]*VW +: VW]);

    always_comb begin
        unique case (st)
            ST_L8:   span = 4'd7;
            ST_L4:   span = 4'd3;
            default: span = 4'd1;
        endcase
    end

    generate
        for (genvar e = 0; e < NE; e++) begin : g_edge
            tt_plane_range #(.CW(CW), .VW(VW), .PICK_MAX(1'b1)) u_rng (
                .a(ea_q[e*CW +: CW]), .b(eb_q[e*CW +: CW]), .c(ec_q[e*CW +: CW]),
                .org_x(org_x), .org_y(org_y), .span(span), .ext(e_hi[e])
            );
            tt_quad_plane #(.CW(CW), .VW(VW)) u_quad (
                .a(ea_q[e*CW +: CW]), .b(eb_q[e*CW +: CW]), .c(ec_q[e*CW +: CW]),
                .qx(org_x[3:1]), .qy(org_y[3:1]), .val(e_px[e])
            );
        end
    endgenerate

    tt_plane_range #(.CW(CW), .VW(VW), .PICK_MAX(1'b0)) u_zmin (
        .a(za_q), .b(zb_q), .c(zc_q),
        .org_x(org_x), .org_y(org_y), .span(span), .ext(z_lo)
    );

    tt_quad_plane #(.CW(CW), .VW(VW)) u_attr (
        .a(ua_q), .b(ub_q), .c(uc_q),
        .qx(org_x[3:1]), .qy(org_y[3:1]), .val(u_px)
    );

    // region test: every edge must reach >= 0 somewhere, depth must not occlude
    always_comb begin
        node_pass = 1'b1;
        for (int e = 0; e < NE; e++) begin
            if (e_hi[e][VW-1]) node_pass = 1'b0;
        end
        if (zen_q && (st == ST_L8) && (z_lo > zmax_sel)) node_pass = 1'b0;
    end

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            cov[k] = 1'b1;
            for (int e = 0; e < NE; e++) begin
                if (e_px[e][k][VW-1]) cov[k] = 1'b0;
            end
        end
    end

    // transitions
    always_comb begin
        st_nx   = st;
        q_nx    = q;
        load    = 1'b0;
        finish  = 1'b0;
        advance = 1'b0;
        adv     = '0;
        unique case (st)
            ST_IDLE: if (start) begin
                st_nx = ST_L8;
                q_nx  = '0;
                load  = 1'b1;
            end
            ST_L8: if (node_pass) st_nx = ST_L4;
                   else begin advance = 1'b1; adv = {1'b0, q[5:4], 4'b0} + 7'd16; end
            ST_L4: if (node_pass) st_nx = ST_L2;
                   else begin advance = 1'b1; adv = {1'b0, q[5:2], 2'b0} + 7'd4; end
            ST_L2: begin advance = 1'b1; adv = {1'b0, q} + 7'd1; end
            default: ;
        endcase
        if (advance) begin
            if (adv[6]) begin
                st_nx  = ST_IDLE;
                finish = 1'b1;
            end else begin
                q_nx  = adv[5:0];
                st_nx = (adv[3:0] == 4'd0) ? ST_L8 :
                        (adv[1:0] == 2'd0) ? ST_L4 : ST_L2;
            end
        end
    end

    // state register and latched triangle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            q      <= '0;
            ea_q   <= '0; eb_q <= '0; ec_q <= '0;
            ua_q   <= '0; ub_q <= '0; uc_q <= '0;
            za_q   <= '0; zb_q <= '0; zc_q <= '0;
            tx_q   <= '0; ty_q <= '0;
            zen_q  <= 1'b0;
            zmax_q <= '0;
        end else begin
            st <= st_nx;
            q  <= q_nx;
            if (load) begin
                ea_q   <= edge_a;  eb_q <= edge_b;  ec_q <= edge_c;
                ua_q   <= attr_a;  ub_q <= attr_b;  uc_q <= attr_c;
                za_q   <= depth_a; zb_q <= depth_b; zc_q <= depth_c;
                tx_q   <= tile_x;  ty_q <= tile_y;
                zen_q  <= zcull_en;
                zmax_q <= zmax_tbl;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quad_valid <= 1'b0;
            quad_x     <= '0;
            quad_y     <= '0;
            quad_mask  <= '0;
            quad_attr  <= '0;
            quad_dx    <= '0;
            quad_dy    <= '0;
            done       <= 1'b0;
        end else begin
            quad_valid <= (st == ST_L2) && (cov != 4'b0);
            done       <= finish;
            if (st == ST_L2) begin
                quad_x    <= tx_q + {{(XW-4){1'b0}}, org_x};
                quad_y    <= ty_q + {{(XW-4){1'b0}}, org_y};
                quad_mask <= cov;
                quad_attr <= u_px[0];
                quad_dx   <= u_px[1] - u_px[0];
                quad_dy   <= u_px[2] - u_px[0];
            end
        end
    end
endmodule

// File: rtl/tile_traverse_chk.sv
module tile_traverse_chk
    import tt_pkg::*;
#(
    parameter  int CW = 16,
    parameter  int XW = 12,
    localparam int VW = CW + 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              quad_valid,
    input logic [XW-1:0]     quad_x,
    input logic [XW-1:0]     quad_y,
    input logic [3:0]        quad_mask,
    input logic [VW-1:0]     quad_dx,
    input logic [VW-1:0]     quad_dy,
    input walk_state_e       st,
    input logic [XW-1:0]     tx_q,
    input logic [XW-1:0]     ty_q,
    input logic [CW-1:0]     ua_q,
    input logic [CW-1:0]     ub_q,
    input logic [3*CW-1:0]   ea_q,
    input logic [3*CW-1:0]   ec_q
);
    logic [XW-1:0] off_x, off_y;
    logic [5:0]    zidx, last_z;
    logic          have_prev;
    logic [VW-1:0] two_a, two_b;

    assign off_x = quad_x - tx_q;
    assign off_y = quad_y - ty_q;
    assign zidx  = {off_y[3], off_x[3], off_y[2], off_x[2], off_y[1], off_x[1]};
    assign two_a = {{(VW-CW-1){ua_q[CW-1]}}, ua_q, 1'b0};
    assign two_b = {{(VW-CW-1){ub_q[CW-1]}}, ub_q, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            last_z    <= '0;
        end else if (done) begin
            have_prev <= 1'b0;
        end else if (quad_valid) begin
            have_prev <= 1'b1;
            last_z    <= zidx;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) && !done |-> !quad_valid);

    assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid |-> (quad_mask != 4'b0));

    assert_zorder_R5: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid && have_prev |-> (zidx > last_z));

    assert_deriv_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid |-> (quad_dx == two_a));

    assert_deriv_y_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid |-> (quad_dy == two_b));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_tri_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(ea_q) && $stable(ec_q));
endmodule

bind tile_traverse tile_traverse_chk #(.CW(CW), .XW(XW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .quad_valid(quad_valid),
    .quad_x(quad_x), .quad_y(quad_y), .quad_mask(quad_mask),
    .quad_dx(quad_dx), .quad_dy(quad_dy), .st(st),
    .tx_q(tx_q), .ty_q(ty_q), .ua_q(ua_q), .ub_q(ub_q),
    .ea_q(ea_q), .ec_q(ec_q)
);

// File: tb/tile_traverse_test.sv
module tile_traverse_test;
    localparam int CW = 16;
    localparam int XW = 12;
    localparam int VW = CW + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3*CW-1:0]   edge_a = '0, edge_b = '0, edge_c = '0;
    logic [XW-1:0]     tile_x = '0, tile_y = '0;
    logic [CW-1:0]     attr_a = '0, attr_b = '0, attr_c = '0;
    logic [CW-1:0]     depth_a = '0, depth_b = '0, depth_c = '0;
    logic              zcull_en = 1'b0;
    logic [4*VW-1:0]   zmax_tbl = '0;
    logic              quad_valid, done;
    logic [XW-1:0]     quad_x, quad_y;
    logic [3:0]        quad_mask;
    logic [VW-1:0]     quad_attr, quad_dx, quad_dy;

    tile_traverse #(.CW(CW), .XW(XW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .edge_a(edge_a), .edge_b(edge_b), .edge_c(edge_c),
        .tile_x(tile_x), .tile_y(tile_y),
        .attr_a(attr_a), .attr_b(attr_b), .attr_c(attr_c),
        .depth_a(depth_a), .depth_b(depth_b), .depth_c(depth_c),
        .zcull_en(zcull_en), .zmax_tbl(zmax_tbl),
        .quad_valid(quad_valid), .quad_x(quad_x), .quad_y(quad_y),
        .quad_mask(quad_mask), .quad_attr(quad_attr),
        .quad_dx(quad_dx), .quad_dy(quad_dy), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int total = 0;
    int bad = 0;

    // triangle description held by the bench
    int ea[3], eb[3], ec[3];
    int ua, ub, uc, za, zb, zc;
    int zt[4];
    bit zen;
    int tx, ty;

    // expected walk
    int    ex_x[64], ex_y[64], ex_m[64];
    longint ex_u[64], ex_dx[64], ex_dy[64];
    int    n_exp, n_cyc;
    bit    last_emit;

    task automatic check(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic longint pv(int a, int b, int c, int px, int py);
        return longint'(a) * (2*px + 1) + longint'(b) * (2*py + 1) + longint'(c);
    endfunction

    function automatic bit region_ok(int x0, int y0, int sz);
        for (int e = 0; e < 3; e++) begin
            bit hit = 1'b0;
            for (int py = y0; py < y0 + sz; py++)
                for (int px = x0; px < x0 + sz; px++)
                    if (pv(ea[e], eb[e], ec[e], px, py) >= 0) hit = 1'b1;
            if (!hit) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit depth_cut(int idx, int x0, int y0);
        longint mn = pv(za, zb, zc, x0, y0);
        if (!zen) return 1'b0;
        for (int py = y0; py < y0 + 8; py++)
            for (int px = x0; px < x0 + 8; px++)
                if (pv(za, zb, zc, px, py) < mn) mn = pv(za, zb, zc, px, py);
        return mn > longint'(zt[idx]);
    endfunction

    function automatic int pix_mask(int x0, int y0);
        int m = 0;
        for (int k = 0; k < 4; k++) begin
            bit in = 1'b1;
            for (int e = 0; e < 3; e++)
                if (pv(ea[e], eb[e], ec[e], x0 + k % 2, y0 + k / 2) < 0) in = 1'b0;
            if (in) m = m | (1 << k);
        end
        return m;
    endfunction

    task automatic build_expect();
        n_exp = 0; n_cyc = 0; last_emit = 1'b0;
        for (int n8 = 0; n8 < 4; n8++) begin
            int x8 = (n8 % 2) * 8;
            int y8 = (n8 / 2) * 8;
            n_cyc++; last_emit = 1'b0;
            if (!region_ok(x8, y8, 8) || depth_cut(n8, x8, y8)) continue;
            for (int n4 = 0; n4 < 4; n4++) begin
                int x4 = x8 + (n4 % 2) * 4;
                int y4 = y8 + (n4 / 2) * 4;
                n_cyc++; last_emit = 1'b0;
                if (!region_ok(x4, y4, 4)) continue;
                for (int n2 = 0; n2 < 4; n2++) begin
                    int x2 = x4 + (n2 % 2) * 2;
                    int y2 = y4 + (n2 / 2) * 2;
                    int m = pix_mask(x2, y2);
                    n_cyc++;
                    last_emit = (m != 0);
                    if (m != 0) begin
                        ex_x[n_exp]  = (tx + x2) % (1 << XW);
                        ex_y[n_exp]  = (ty + y2) % (1 << XW);
                        ex_m[n_exp]  = m;
                        ex_u[n_exp]  = pv(ua, ub, uc, x2, y2);
                        ex_dx[n_exp] = pv(ua, ub, uc, x2 + 1, y2) - pv(ua, ub, uc, x2, y2);
                        ex_dy[n_exp] = pv(ua, ub, uc, x2, y2 + 1) - pv(ua, ub, uc, x2, y2);
                        n_exp++;
                    end
                end
            end
        end
    endtask

    task automatic drive_inputs();
        for (int e = 0; e < 3; e++) begin
            edge_a[e*CW +: CW] = ea[e][CW-1:0];
            edge_b[e*CW +: CW] = eb[e][CW-1:0];
            edge_c[e*CW +: CW] = ec[e][CW-1:0];
        end
        attr_a = ua[CW-1:0]; attr_b = ub[CW-1:0]; attr_c = uc[CW-1:0];
        depth_a = za[CW-1:0]; depth_b = zb[CW-1:0]; depth_c = zc[CW-1:0];
        for (int i = 0; i < 4; i++) zmax_tbl[i*VW +: VW] = zt[i][VW-1:0];
        zcull_en = zen;
        tile_x = tx[XW-1:0];
        tile_y = ty[XW-1:0];
    endtask

    function automatic int rs(int lo, int hi);
        return lo + int'($urandom_range(0, hi - lo));
    endfunction

    task automatic run_walk(input bit disturb);
        int cyc = 0;
        int idx = 0;
        build_expect();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) begin
                start = 1'b1;           // R10: must be ignored mid-walk
                edge_c = ~edge_c;
                attr_a = ~attr_a;
            end
            if (disturb && cyc == 4) start = 1'b0;
            if (quad_valid) begin
                if (idx >= n_exp) begin
                    check("R6 extra quad", idx, n_exp);
                end else begin
                    check("R9 quad_x", quad_x, ex_x[idx]);
                    check("R9 quad_y", quad_y, ex_y[idx]);
                    check("R2 quad_mask", quad_mask, ex_m[idx]);
                    check("R8 quad_attr", longint'($signed(quad_attr)), ex_u[idx]);
                    check("R8 quad_dx", longint'($signed(quad_dx)), ex_dx[idx]);
                    check("R8 quad_dy", longint'($signed(quad_dy)), ex_dy[idx]);
                end
                idx++;
            end
            if (done) begin
                check("R4 walk cycles", cyc, n_cyc);
                check("R3 R5 R7 quad count", idx, n_exp);
                check("R11 last quad with done", quad_valid, last_emit);
                break;
            end
            if (cyc > 200) begin
                check("R4 done missing", cyc, n_cyc);
                break;
            end
        end
        @(negedge clk);
        check("R10 done single cycle", done, 0);
        check("R10 no quad after done", quad_valid, 0);
    endtask

    task automatic set_full();
        for (int e = 0; e < 3; e++) begin ea[e] = 0; eb[e] = 0; ec[e] = 1; end
        ua = 3; ub = -5; uc = 10;
        za = 0; zb = 0; zc = 0; zen = 1'b0;
        for (int i = 0; i < 4; i++) zt[i] = 0;
        tx = 32; ty = 48;
    endtask

    initial begin : watchdog
        int n = 0;
        forever begin
            @(posedge clk);
            n++;
            if (n > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog got=%0d exp=<150000", n);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 quad_valid at reset", quad_valid, 0);
        check("R1 done at reset", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 quad_valid idle", quad_valid, 0);
        check("R1 done idle", done, 0);

        // full coverage: 84 tests, final quad lands with done (R11)
        set_full();
        run_walk(1'b0);

        // nothing covered: only four 8x8 tests (R3)
        set_full(); ec[0] = -1;
        run_walk(1'b0);

        // edge value exactly zero counts as inside (R2)
        set_full(); for (int e = 0; e < 3; e++) ec[e] = 0;
        run_walk(1'b0);

        // single column x=1, y>=1: masks 8 then 0xA (R2 bit order)
        set_full();
        ea[0] = 1;  eb[0] = 0; ec[0] = -3;
        ea[1] = -1; eb[1] = 0; ec[1] = 3;
        ea[2] = 0;  eb[2] = 1; ec[2] = -3;
        run_walk(1'b0);

        // left half only
        set_full(); ea[0] = -1; ec[0] = 16;
        run_walk(1'b0);

        // depth rejection: regions 1 and 3 culled, region 2 equal so kept (R7)
        set_full(); zen = 1'b1; zc = 100;
        zt[0] = 200; zt[1] = 50; zt[2] = 100; zt[3] = 99;
        run_walk(1'b0);

        // same table with rejection disabled has no effect (R7)
        zen = 1'b0;
        run_walk(1'b0);

        // start pulse and changed inputs during the walk (R10)
        set_full(); ea[0] = -1; eb[0] = 1; ec[0] = 8;
        run_walk(1'b1);

        for (int t = 0; t < 40; t++) begin
            for (int e = 0; e < 3; e++) begin
                ea[e] = rs(-64, 63);
                eb[e] = rs(-64, 63);
                ec[e] = rs(-600, 1500);
            end
            ua = rs(-2000, 2000); ub = rs(-2000, 2000); uc = rs(-20000, 20000);
            za = rs(-32, 32); zb = rs(-32, 32); zc = rs(-1000, 1000);
            for (int i = 0; i < 4; i++) zt[i] = rs(-2000, 2000);
            zen = 1'($urandom_range(0, 1));
            tx = rs(0, 255) * 16;
            ty = rs(0, 255) * 16;
            run_walk(1'($urandom_range(0, 3) == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule